// File: doc/BRIEF.md
# Flash Write-Protection Range Checker

This block guards a program-flash controller. Every read, write or erase request is checked before it reaches the array. The answer is either grant or reject. The decision depends on a small configuration word, which the block captures once after reset. That word holds:

- a global internal write lock;
- a global external access lock;
- a segment-protection disable bit;
- an anchor-select bit;
- an extra lock for the final page;
- a 7-bit page pointer.

Memory is divided into pages of 512 words. The page pointer names the inner edge of a protected segment, and the segment includes that page. The segment reaches either down to page 0 or up to the last implemented page. When the segment is anchored at the bottom, the final page, which holds the configuration words, can be locked as well. Segment protection is added on top of the global locks and never loosens them.

A request is qualified by a one-cycle strobe, and its result appears one cycle later. Every rejected request also sets a sticky violation flag, which software clears with a clear input.

Top module: `fwp_gate`

## Requirements
- R1: The configuration pins are sampled at the first rising clock edge that sees `rst_n` high. Later changes on those pins have no effect until the next reset.
- R2: A request presented with `req_valid` high produces `resp_valid` high in the next cycle, with `resp_grant` holding the decision. `resp_valid` is low in every cycle that follows a cycle without a request, and `resp_grant` is never high without `resp_valid`.
- R3: The read operation (`req_op` = 2'b00) from internal code (`req_ext` = 0) is always granted once the configuration is captured.
- R4: When `cfg_gcp_n` = 0, every external request (`req_ext` = 1) is rejected, whether read, write or erase. When `cfg_gcp_n` = 1, external reads are granted.
- R5: When `cfg_gwp_n` = 0, every internal modifying request is rejected, whatever the segment bits say. The modifying ops are `req_op` = 2'b01 (write), 2'b10 (erase) and 2'b11 (treated as write). External requests are not affected by this bit.
- R6: When `cfg_seg_dis` = 1, no segment protection applies, and the page pointer, anchor and last-page bits have no effect.
- R7: When `cfg_seg_dis` = 0 and `cfg_anchor_top` = 0, modifying requests are rejected for pages 0 through the pointer page inclusive. The page is `req_addr[15:9]`.
- R8: When `cfg_seg_dis` = 0 and `cfg_anchor_top` = 1, modifying requests are rejected from the pointer page through page 127 inclusive.
- R9: When `cfg_seg_dis` = 0, `cfg_anchor_top` = 0 and `cfg_lastpg_n` = 0, page 127 is protected in addition to the bottom segment. With `cfg_anchor_top` = 1 the last-page bit changes nothing.
- R10: `violation` rises in the same cycle as a rejected response. It stays high until `viol_clr` is seen in a cycle with no rejected request. A reject in the same cycle as a clear wins.
- R11: A request presented in the capture cycle (the first cycle after reset release) is rejected.
- R12: While reset is held, `resp_valid`, `resp_grant` and `violation` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_gwp_n | input | 1 | Global internal write lock, active low |
| cfg_gcp_n | input | 1 | Global external access lock, active low |
| cfg_seg_dis | input | 1 | 1 disables segment protection |
| cfg_anchor_top | input | 1 | 0: segment from page 0 up; 1: segment from pointer to top |
| cfg_lastpg_n | input | 1 | 0 adds the final page to a bottom segment |
| cfg_page_ptr | input | 7 | Inner boundary page of the segment |
| req_valid | input | 1 | Request strobe |
| req_addr | input | 16 | Word address |
| req_op | input | 2 | 00 read, 01 write, 10 erase, 11 treated as write |
| req_ext | input | 1 | 1 for an external programmer access |
| viol_clr | input | 1 | Clears the violation flag |
| resp_valid | output | 1 | Decision valid |
| resp_grant | output | 1 | 1 grant, 0 reject |
| violation | output | 1 | Sticky reject flag |

## Verification
The bench targets the pages right at both sides of the pointer, page 0 and page 127. A design with an exclusive boundary, or one that compares the wrong way, would grant the pointer page or reject its neighbour. The bench also checks that the last-page bit protects page 127 only for a bottom segment. It checks that the global internal lock leaves external writes alone, and that the external lock blocks external reads while internal reads still pass. Finally, it changes the configuration pins after capture and sends a request in the capture cycle itself. A design that samples the pins continuously, or that decides before capture, would give a different answer in those cases.

// File: rtl/fwp_pkg.sv
package fwp_pkg;

    localparam int PTR_W = 7;

    typedef enum logic [1:0] {
        OP_READ  = 2'b00,
        OP_WRITE = 2'b01,
        OP_ERASE = 2'b10,
        OP_RSVD  = 2'b11
    } op_e;

    typedef struct packed {
        logic             gwp_n;
        logic             gcp_n;
        logic             seg_dis;
        logic             anchor_top;
        logic             lastpg_n;
        logic [PTR_W-1:0] ptr;
    } cfg_t;

    typedef struct packed {
        cfg_t cfg;
        logic armed;
    } hold_t;

    typedef struct packed {
        logic valid;
        logic grant;
        logic viol;
    } resp_t;

endpackage

// File: rtl/fwp_cfg_hold.sv
module fwp_cfg_hold
    import fwp_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  cfg_t cfg_in,
    output cfg_t cfg_q,
    output logic armed_q
);

    hold_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!st_q.armed) begin
            st_d.cfg   = cfg_in;
            st_d.armed = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cfg_q   = st_q.cfg;
    assign armed_q = st_q.armed;

endmodule

// File: rtl/fwp_seg_match.sv
module fwp_seg_match #(
    parameter int NUM_PAGES = 128,
    parameter int PTR_W     = 7,
    localparam int PG_W     = $clog2(NUM_PAGES),
    localparam int CW       = (PG_W > PTR_W) ? PG_W : PTR_W
) (
    input  logic [PG_W-1:0]  page,
    input  logic             seg_dis,
    input  logic             anchor_top,
    input  logic             lastpg_n,
    input  logic [PTR_W-1:0] ptr,
    output logic             seg_hit
);

    localparam logic [CW-1:0] LAST_PG = CW'(NUM_PAGES - 1);

    logic [CW-1:0] pg_x, ptr_x;
    logic          below_hit, above_hit, last_hit;

    assign pg_x  = CW'(page);
    assign ptr_x = CW'(ptr);

    always_comb begin
        below_hit = (pg_x <= ptr_x);
        above_hit = (pg_x >= ptr_x);
        last_hit  = (pg_x == LAST_PG) && !lastpg_n;
        if (seg_dis)         seg_hit = 1'b0;
        else if (anchor_top) seg_hit = above_hit;
        else                 seg_hit = below_hit || last_hit;
    end

endmodule

// File: rtl/fwp_policy.sv
module fwp_policy
    import fwp_pkg::*;
(
    input  logic       armed,
    input  logic       gwp_n,
    input  logic       gcp_n,
    input  logic [1:0] op,
    input  logic       ext,
    input  logic       seg_hit,
    output logic       allow
);

    logic is_read;

    always_comb begin
        is_read = (op == OP_READ);
        if (!armed)       allow = 1'b0;
        else if (ext)     allow = gcp_n && (is_read || !seg_hit);
        else if (is_read) allow = 1'b1;
        else              allow = gwp_n && !seg_hit;
    end

endmodule

// File: rtl/fwp_gate.sv
module fwp_gate
    import fwp_pkg::*;
#(
    parameter int NUM_PAGES = 128,
    parameter int PAGE_LG   = 9,
    localparam int PG_W     = $clog2(NUM_PAGES),
    localparam int ADDR_W   = PG_W + PAGE_LG
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_gwp_n,
    input  logic              cfg_gcp_n,
    input  logic              cfg_seg_dis,
    input  logic              cfg_anchor_top,
    input  logic              cfg_lastpg_n,
    input  logic [PTR_W-1:0]  cfg_page_ptr,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [1:0]        req_op,
    input  logic              req_ext,
    input  logic              viol_clr,
    output logic              resp_valid,
    output logic              resp_grant,
    output logic              violation
);

    cfg_t            cfg_pins, cfg_cap;
    logic            cfg_armed;
    logic [PG_W-1:0] req_page;
    logic            seg_hit, allow;
    logic            unused_offset;
    resp_t           rs_d, rs_q;

    assign cfg_pins = '{gwp_n:      cfg_gwp_n,
                        gcp_n:      cfg_gcp_n,
                        seg_dis:    cfg_seg_dis,
                        anchor_top: cfg_anchor_top,
                        lastpg_n:   cfg_lastpg_n,
                        ptr:        cfg_page_ptr};

    assign req_page      = req_addr[ADDR_W-1 -: PG_W];
    assign unused_offset = ^req_addr[PAGE_LG-1:0];

    fwp_cfg_hold u_hold (
        .clk     (clk),
        .rst_n   (rst_n),
        .cfg_in  (cfg_pins),
        .cfg_q   (cfg_cap),
        .armed_q (cfg_armed)
    );

    fwp_seg_match #(.NUM_PAGES(NUM_PAGES), .PTR_W(PTR_W)) u_seg (
        .page       (req_page),
        .seg_dis    (cfg_cap.seg_dis),
        .anchor_top (cfg_cap.anchor_top),
        .lastpg_n   (cfg_cap.lastpg_n),
        .ptr        (cfg_cap.ptr),
        .seg_hit    (seg_hit)
    );

    fwp_policy u_pol (
        .armed   (cfg_armed),
        .gwp_n   (cfg_cap.gwp_n),
        .gcp_n   (cfg_cap.gcp_n),
        .op      (req_op),
        .ext     (req_ext),
        .seg_hit (seg_hit),
        .allow   (allow)
    );

    always_comb begin
        rs_d       = rs_q;
        rs_d.valid = req_valid;
        rs_d.grant = req_valid && allow;
        if (viol_clr)               rs_d.viol = 1'b0;
        if (req_valid && !allow)    rs_d.viol = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rs_q <= '0;
        else        rs_q <= rs_d;
    end

    assign resp_valid = rs_q.valid;
    assign resp_grant = rs_q.grant;
    assign violation  = rs_q.viol;

endmodule

// File: rtl/fwp_gate_chk.sv
module fwp_gate_chk
    import fwp_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       req_valid,
    input logic [1:0] req_op,
    input logic       req_ext,
    input logic       viol_clr,
    input logic       resp_valid,
    input logic       resp_grant,
    input logic       violation,
    input logic       armed,
    input cfg_t       cap_cfg
);

    a_r1_cfg_held: assert property (@(posedge clk) disable iff (!rst_n)
        armed |=> $stable(cap_cfg));

    a_r2_resp_follows: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> resp_valid);

    a_r2_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !resp_valid);

    a_r2_grant_qualified: assert property (@(posedge clk) disable iff (!rst_n)
        resp_grant |-> resp_valid);

    a_r3_int_read: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && armed && req_op == 2'b00 && !req_ext) |=> resp_grant);

    a_r4_ext_locked: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ext && !cap_cfg.gcp_n) |=> !resp_grant);

    a_r5_int_write_locked: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_ext && req_op != 2'b00 && !cap_cfg.gwp_n) |=> !resp_grant);

    a_r10_reject_flags: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && !resp_grant) |-> violation);

    a_r10_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (violation && !viol_clr) |=> violation);

    a_r11_prearm_reject: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !armed) |=> !resp_grant);

endmodule

bind fwp_gate fwp_gate_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_op     (req_op),
    .req_ext    (req_ext),
    .viol_clr   (viol_clr),
    .resp_valid (resp_valid),
    .resp_grant (resp_grant),
    .violation  (violation),
    .armed      (cfg_armed),
    .cap_cfg    (cfg_cap)
);

// File: tb/fwp_gate_tb.sv
module fwp_gate_tb;

    typedef struct {
        logic  exp;
        string tag;
    } sb_item_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_gwp_n = 1'b1, cfg_gcp_n = 1'b1, cfg_seg_dis = 1'b1;
    logic        cfg_anchor_top = 1'b0, cfg_lastpg_n = 1'b1;
    logic [6:0]  cfg_page_ptr = '0;
    logic        req_valid = 1'b0;
    logic [15:0] req_addr = '0;
    logic [1:0]  req_op = 2'b00;
    logic        req_ext = 1'b0;
    logic        viol_clr = 1'b0;
    logic        resp_valid, resp_grant, violation;

    int n_cmp = 0, n_bad = 0;
    bit finished = 0;
    sb_item_t sbq[$];

    logic [11:0] mcfg;
    bit          m_armed;

    always #5 clk = ~clk;

    fwp_gate u_dut (
        .clk(clk), .rst_n(rst_n),
        .cfg_gwp_n(cfg_gwp_n), .cfg_gcp_n(cfg_gcp_n), .cfg_seg_dis(cfg_seg_dis),
        .cfg_anchor_top(cfg_anchor_top), .cfg_lastpg_n(cfg_lastpg_n),
        .cfg_page_ptr(cfg_page_ptr),
        .req_valid(req_valid), .req_addr(req_addr), .req_op(req_op), .req_ext(req_ext),
        .viol_clr(viol_clr),
        .resp_valid(resp_valid), .resp_grant(resp_grant), .violation(violation)
    );

    task automatic check(input logic got, input logic exp, input string tag);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %b expected %b at %0t", tag, got, exp, $time);
        end
    endtask

    // mcfg = {gwp_n, gcp_n, seg_dis, anchor_top, lastpg_n, ptr[6:0]}
    function automatic logic model(input logic [11:0] c, input logic [15:0] a,
                                   input logic [1:0] op, input logic ext);
        logic [6:0] pg, ptr;
        logic seg;
        pg  = a[15:9];
        ptr = c[6:0];
        seg = !c[9] && (c[8] ? (pg >= ptr) : ((pg <= ptr) || (!c[7] && pg == 7'd127)));
        if (op == 2'b00) return ext ? c[10] : 1'b1;
        if (ext)         return c[10] && !seg;
        return c[11] && !seg;
    endfunction

    task automatic do_reset(input logic gwp, input logic gcp, input logic sd,
                            input logic at, input logic lp, input logic [6:0] p);
        @(negedge clk);
        rst_n = 1'b0;
        req_valid = 1'b0;
        viol_clr = 1'b0;
        {cfg_gwp_n, cfg_gcp_n, cfg_seg_dis, cfg_anchor_top, cfg_lastpg_n, cfg_page_ptr}
            = {gwp, gcp, sd, at, lp, p};
        mcfg = {gwp, gcp, sd, at, lp, p};
        m_armed = 0;
        repeat (2) @(negedge clk);
        check(resp_valid, 1'b0, "R12 resp_valid in reset");
        check(resp_grant, 1'b0, "R12 resp_grant in reset");
        check(violation, 1'b0, "R12 violation in reset");
        rst_n = 1'b1;
    endtask

    task automatic send(input logic [15:0] a, input logic [1:0] op, input logic ext,
                        input string tag);
        sb_item_t it;
        req_valid = 1'b1;
        req_addr  = a;
        req_op    = op;
        req_ext   = ext;
        it.exp = m_armed ? model(mcfg, a, op, ext) : 1'b0;
        it.tag = tag;
        sbq.push_back(it);
        @(negedge clk);
        req_valid = 1'b0;
        m_armed = 1;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
        m_armed = 1;
    endtask

    // monitor: pops the scoreboard whenever a decision appears
    always @(negedge clk) begin
        if (rst_n && resp_valid) begin
            if (sbq.size() == 0) begin
                n_cmp++; n_bad++;
                $display("FAIL R2: got unexpected response expected none at %0t", $time);
            end else begin
                sb_item_t it;
                it = sbq.pop_front();
                check(resp_grant, it.exp, it.tag);
            end
        end
    end

    initial begin
        // R11 and R7: bottom segment up to page 10
        do_reset(1, 1, 0, 0, 1, 7'd10);
        send(16'h0000, 2'b00, 0, "R11 request in capture cycle");
        send(16'h15FF, 2'b01, 0, "R7 last word of pointer page");
        send(16'h1600, 2'b01, 0, "R7 first word above pointer page");
        send(16'h0000, 2'b10, 0, "R7 page 0 erase");
        send(16'hFE00, 2'b01, 0, "R9 page 127 open when last-page bit 1");
        send(16'h0000, 2'b00, 0, "R3 internal read in segment");
        send(16'h0100, 2'b11, 1, "R7 external write in segment");
        send(16'h2800, 2'b01, 1, "R4 external write outside segment");
        // R1: pin changes after capture are ignored
        cfg_gwp_n = 1'b0; cfg_seg_dis = 1'b1; cfg_page_ptr = 7'd0;
        send(16'h1600, 2'b01, 0, "R1 pins changed, page 11 still open");
        send(16'h0200, 2'b01, 0, "R1 pins changed, page 1 still locked");
        idle(1);

        // R9: last page added to bottom segment
        do_reset(1, 1, 0, 0, 0, 7'd10);
        idle(1);
        send(16'hFFFF, 2'b01, 0, "R9 page 127 locked");
        send(16'hFC00, 2'b01, 0, "R9 page 126 open");
        send(16'h0A00, 2'b10, 0, "R7 page 5 erase");

        // R8: top segment from page 100
        do_reset(1, 1, 0, 1, 1, 7'd100);
        idle(1);
        send(16'hC7FF, 2'b01, 0, "R8 page 99 open");
        send(16'hC800, 2'b10, 0, "R8 pointer page locked");
        send(16'hFFFF, 2'b01, 0, "R8 page 127 locked");
        send(16'hC800, 2'b00, 0, "R3 internal read in top segment");
        do_reset(1, 1, 0, 1, 0, 7'd100);
        idle(1);
        send(16'hC7FF, 2'b01, 0, "R9 top anchor ignores last-page bit");

        // R6: segment disabled
        do_reset(1, 1, 1, 0, 0, 7'd10);
        idle(1);
        send(16'h0000, 2'b01, 0, "R6 page 0 open with segment off");
        send(16'hFE00, 2'b10, 0, "R6 page 127 open with segment off");

        // R5: internal write lock
        do_reset(0, 1, 1, 0, 1, 7'd0);
        idle(1);
        send(16'h4000, 2'b01, 0, "R5 internal write locked");
        send(16'h6400, 2'b10, 0, "R5 internal erase locked");
        send(16'h6400, 2'b00, 0, "R3 internal read with write lock");
        send(16'h6400, 2'b01, 1, "R5 external write unaffected");

        // R4: external lock
        do_reset(1, 0, 1, 0, 1, 7'd0);
        idle(1);
        send(16'h1234, 2'b00, 1, "R4 external read locked");
        send(16'h1234, 2'b00, 0, "R3 internal read with external lock");
        send(16'h1234, 2'b10, 1, "R4 external erase locked");
        send(16'h1234, 2'b01, 0, "R4 internal write unaffected");
        send(16'h0000, 2'b00, 1, "R4 external read locked page 0");

        // R10: sticky violation
        viol_clr = 1'b1;
        @(negedge clk);
        viol_clr = 1'b0;
        check(violation, 1'b0, "R10 cleared");
        send(16'h0000, 2'b00, 1, "R4 reject for R10");
        check(violation, 1'b1, "R10 set with reject");
        idle(3);
        check(violation, 1'b1, "R10 held");
        viol_clr = 1'b1;
        send(16'h0000, 2'b00, 1, "R4 reject with clear");
        viol_clr = 1'b0;
        check(violation, 1'b1, "R10 set wins over clear");
        viol_clr = 1'b1;
        @(negedge clk);
        viol_clr = 1'b0;
        check(violation, 1'b0, "R10 clear alone");
        idle(2);

        if (sbq.size() != 0) begin
            n_cmp++; n_bad++;
            $display("FAIL R2: got %0d missing responses expected 0", sbq.size());
        end
        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_cmp++; n_bad++;
            $display("FAIL R2: got hang expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule